// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Line-Break Detection

This block turns an asynchronous serial line into parallel characters. A shared enable pulse, sixteen per bit time, sets the sampling rate. The input passes through a two-stage synchronizer. A low level on the idle line starts a character, and the receiver then samples each bit at its midpoint. The character format comes from static configuration inputs:

- five to eight data bits, received least-significant bit first;
- no parity, odd parity or even parity;
- one or two stop bits.

For each character the block gives a one-clock valid pulse, the right-aligned data and three tags: parity error, framing error and break.

A line held low for longer than a whole frame is a line break. A break gives exactly one all-zero character that carries all three tags. After that, no further character is accepted until the line has been high for at least one bit time.

A stop bit sampled low gives a framing error, and the receiver then resynchronises. It takes that low level as the start bit of the next character and samples the following data bits from that point. The configuration inputs must be held stable while a character is being received.

Top module: `serial_rx_core`

## Requirements
- R1: While rst_ni is low, char_valid_o, perr_o, ferr_o and brk_o are 0. After reset, an idle line that stays high produces no character.
- R2: A start bit is accepted only if the line is still low at its midpoint, eight sample ticks after the falling edge is seen. A shorter low pulse produces no character.
- R3: Data bits are received least-significant bit first. width_sel_i sets the count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. char_data_o is right-aligned and its unused upper bits are 0.
- R4: With par_en_i = 1, a parity bit follows the data. With par_odd_i = 0 (even parity), the data bits and the parity bit together hold an even number of ones; with par_odd_i = 1 (odd parity), an odd number. A mismatch sets perr_o. With par_en_i = 0 no parity bit is expected and perr_o stays 0, except on a break character.
- R5: two_stop_i = 1 selects two stop bits. ferr_o is set if any stop bit is sampled low. A character with all stop bits high has ferr_o = 0.
- R6: When a stop bit is sampled low and the character was not all low, the receiver emits that character with ferr_o and takes the low level as the start bit of the next character. The next character's data bits are sampled from one bit time later.
- R7: A line held low for more than the frame length (start, data, parity and stop bits, times 16 ticks) produces exactly one character: data 0 with brk_o, ferr_o and perr_o all 1. An all-low character that ends before that limit is reported with ferr_o and without brk_o.
- R8: After a break, no character is produced until the line has been high for at least 16 consecutive ticks.
- R9: char_valid_o is a single-clock pulse. perr_o, ferr_o and brk_o are 0 whenever char_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Sample enable, 16 pulses per bit time |
| rx_i | input | 1 | Asynchronous serial input, idle high |
| width_sel_i | input | 2 | Data bit count minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop_i | input | 1 | 1 = two stop bits |
| char_valid_o | output | 1 | One-clock pulse per received character |
| char_data_o | output | 8 | Received data, right-aligned |
| perr_o | output | 1 | Parity error tag |
| ferr_o | output | 1 | Framing error tag |
| brk_o | output | 1 | Line break tag |

## Verification
The assertions check on every cycle the properties that must hold for every character:
- char_valid_o is a single-clock pulse, and the tags are silent between characters;
- a break character is always zero and carries all three tags;
- parity errors never appear with parity disabled, except on a break;
- the data never has bits set above the selected width.

Only the bench scenarios can show the behaviour that depends on timing:
- a short glitch is rejected;
- the receiver resynchronises onto the low stop bit after a framing error;
- a break yields one character rather than several;
- an all-low character that ends just short of the frame length is not a break;
- the receiver stays blocked until the line has been high for a full bit time.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DATA_W   = 8;
  localparam int MIN_BITS = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK_WAIT,
    ST_BRK_HOLD
  } rx_state_e;

  typedef struct packed {
    logic [1:0] width_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } rx_cfg_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  // reset to the idle (high) line level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_run_timer.sv
module rx_run_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             line_i,
  output logic [CNT_W-1:0] low_run_o,
  output logic [CNT_W-1:0] high_run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] low_q, high_q;

  // consecutive low / high tick counts, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q  <= '0;
      high_q <= '0;
    end else if (tick_i) begin
      if (!line_i) begin
        high_q <= '0;
        if (low_q != CNT_MAX) low_q <= low_q + 1'b1;
      end else begin
        low_q <= '0;
        if (high_q != CNT_MAX) high_q <= high_q + 1'b1;
      end
    end
  end

  assign low_run_o  = low_q;
  assign high_run_o = high_q;
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              line_i,
  input  rx_cfg_t           cfg_i,
  input  logic [CNT_W-1:0]  low_run_i,
  input  logic [CNT_W-1:0]  high_run_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  localparam int TICK_W = $clog2(OSR);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam logic [TICK_W-1:0] MID_TICK  = TICK_W'(OSR / 2 - 1);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(OSR - 1);

  rx_state_e         state_q;
  logic [TICK_W-1:0] tick_cnt_q;
  logic [IDX_W-1:0]  bit_idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_q;
  logic              all_low_q;
  logic              stop_idx_q;

  logic              valid_q, perr_q, ferr_q, brk_q;
  logic [DATA_W-1:0] data_q;

  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W-1:0] data_aligned;
  logic              par_bad;
  logic [3:0]        frame_bits;
  logic [CNT_W-1:0]  frame_ticks;

  always_comb begin
    last_idx     = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_i.width_sel);
    data_aligned = shreg_q >> (2'd3 - cfg_i.width_sel);
    // unreceived bits are zero, so the reduction covers the live bits only
    par_bad      = cfg_i.par_en && (par_q != ((^shreg_q) ^ cfg_i.par_odd));
    frame_bits   = 4'(MIN_BITS + 2) + 4'(cfg_i.width_sel)
                 + 4'(cfg_i.par_en) + 4'(cfg_i.two_stop);
    frame_ticks  = CNT_W'(frame_bits) * CNT_W'(OSR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shreg_q    <= '0;
      par_q      <= 1'b0;
      all_low_q  <= 1'b0;
      stop_idx_q <= 1'b0;
      valid_q    <= 1'b0;
      data_q     <= '0;
      perr_q     <= 1'b0;
      ferr_q     <= 1'b0;
      brk_q      <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      brk_q   <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (!line_i) begin
              state_q    <= ST_START;
              tick_cnt_q <= '0;
            end
          end
          ST_START: begin
            if (tick_cnt_q == MID_TICK) begin
              tick_cnt_q <= '0;
              if (!line_i) begin
                state_q   <= ST_DATA;
                bit_idx_q <= '0;
                shreg_q   <= '0;
                all_low_q <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              tick_cnt_q <= tick_cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (tick_cnt_q == LAST_TICK) begin
              tick_cnt_q <= '0;
              shreg_q    <= {line_i, shreg_q[DATA_W-1:1]};
              all_low_q  <= all_low_q & ~line_i;
              bit_idx_q  <= bit_idx_q + 1'b1;
              stop_idx_q <= 1'b0;
              if (bit_idx_q == last_idx)
                state_q <= cfg_i.par_en ? ST_PAR : ST_STOP;
            end else begin
              tick_cnt_q <= tick_cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            if (tick_cnt_q == LAST_TICK) begin
              tick_cnt_q <= '0;
              par_q      <= line_i;
              all_low_q  <= all_low_q & ~line_i;
              state_q    <= ST_STOP;
            end else begin
              tick_cnt_q <= tick_cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (tick_cnt_q == LAST_TICK) begin
              tick_cnt_q <= '0;
              if (line_i) begin
                if (cfg_i.two_stop && !stop_idx_q) begin
                  stop_idx_q <= 1'b1;
                end else begin
                  valid_q <= 1'b1;
                  data_q  <= data_aligned;
                  perr_q  <= par_bad;
                  state_q <= ST_IDLE;
                end
              end else if (all_low_q) begin
                state_q <= ST_BRK_WAIT;
              end else begin
                // framing error: the low stop level becomes the next start bit
                valid_q   <= 1'b1;
                data_q    <= data_aligned;
                perr_q    <= par_bad;
                ferr_q    <= 1'b1;
                state_q   <= ST_DATA;
                bit_idx_q <= '0;
                shreg_q   <= '0;
                all_low_q <= 1'b1;
              end
            end else begin
              tick_cnt_q <= tick_cnt_q + 1'b1;
            end
          end
          ST_BRK_WAIT: begin
            if (line_i) begin
              valid_q <= 1'b1;
              data_q  <= '0;
              perr_q  <= par_bad;
              ferr_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (low_run_i > frame_ticks) begin
              valid_q <= 1'b1;
              data_q  <= '0;
              perr_q  <= 1'b1;
              ferr_q  <= 1'b1;
              brk_q   <= 1'b1;
              state_q <= ST_BRK_HOLD;
            end
          end
          ST_BRK_HOLD: begin
            if (high_run_i >= CNT_W'(OSR)) state_q <= ST_IDLE;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign perr_o  = perr_q;
  assign ferr_o  = ferr_q;
  assign brk_o   = brk_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic [1:0]        width_sel_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              char_valid_o,
  output logic [DATA_W-1:0] char_data_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              brk_o
);
  // longest frame: start + data + parity + two stop, plus margin for "longer than"
  localparam int CNT_W = $clog2(OSR * (DATA_W + 4) + 2);

  logic             line_s;
  logic [CNT_W-1:0] low_run, high_run;
  rx_cfg_t          cfg;

  assign cfg = '{width_sel: width_sel_i, par_en: par_en_i,
                 par_odd: par_odd_i, two_stop: two_stop_i};

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rx_i),
    .q_o    (line_s)
  );

  rx_run_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .line_i     (line_s),
    .low_run_o  (low_run),
    .high_run_o (high_run)
  );

  rx_frame_fsm #(.OSR(OSR), .CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick16_i),
    .line_i     (line_s),
    .cfg_i      (cfg),
    .low_run_i  (low_run),
    .high_run_i (high_run),
    .valid_o    (char_valid_o),
    .data_o     (char_data_o),
    .perr_o     (perr_o),
    .ferr_o     (ferr_o),
    .brk_o      (brk_o)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] width_sel_i,
  input logic       par_en_i,
  input logic       char_valid_o,
  input logic [7:0] char_data_o,
  input logic       perr_o,
  input logic       ferr_o,
  input logic       brk_o
);
  logic [7:0] width_mask;
  assign width_mask = 8'hFF >> (2'd3 - width_sel_i);

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o); // R9
  AST_TAGS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !char_valid_o |-> !(perr_o || ferr_o || brk_o)); // R9
  AST_BRK_TAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_o && brk_o) |-> (ferr_o && perr_o && char_data_o == 8'h00)); // R7
  AST_NO_PERR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_o && !par_en_i && !brk_o) |-> !perr_o); // R4
  AST_DATA_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> ((char_data_o & ~width_mask) == 8'h00)); // R3
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .width_sel_i  (width_sel_i),
  .par_en_i     (par_en_i),
  .char_valid_o (char_valid_o),
  .char_data_o  (char_data_o),
  .perr_o       (perr_o),
  .ferr_o       (ferr_o),
  .brk_o        (brk_o)
);

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 2;
  localparam int OSR        = 16;
  localparam int NVEC       = 12;

  // {width_sel[1:0], par_en, par_odd, two_stop, data[7:0], bad_parity}
  localparam logic [13:0] VEC [NVEC] = '{
    {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0},
    {2'd3, 1'b1, 1'b0, 1'b0, 8'h3C, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h3C, 1'b1},
    {2'd2, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h2D, 1'b0},
    {2'd0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b0, 8'h13, 1'b1},
    {2'd3, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},
    {2'd2, 1'b1, 1'b1, 1'b0, 8'h55, 1'b1},
    {2'd1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0},
    {2'd3, 1'b1, 1'b1, 1'b1, 8'h80, 1'b0},
    {2'd0, 1'b1, 1'b1, 1'b0, 8'h0A, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] wsel = 2'd3;
  logic       pen = 1'b0, podd = 1'b0, two = 1'b0;
  logic       char_valid;
  logic [7:0] char_data;
  logic       perr, ferr, brk;

  int div_cnt = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [7:0] cap_d [64];
  logic [2:0] cap_f [64]; // {brk, ferr, perr}
  int cap_n = 0;

  serial_rx_core u_serial_rx_core (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .tick16_i     (tick),
    .rx_i         (rx),
    .width_sel_i  (wsel),
    .par_en_i     (pen),
    .par_odd_i    (podd),
    .two_stop_i   (two),
    .char_valid_o (char_valid),
    .char_data_o  (char_data),
    .perr_o       (perr),
    .ferr_o       (ferr),
    .brk_o        (brk)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    div_cnt <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
    tick    <= (div_cnt == TICK_DIV - 1);
  end

  always @(negedge clk) begin
    if (char_valid && cap_n < 64) begin
      cap_d[cap_n] = char_data;
      cap_f[cap_n] = {brk, ferr, perr};
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input bit lvl, input int ticks);
    rx <= lvl;
    repeat (ticks * TICK_DIV) @(posedge clk);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) hold(d[i], OSR);
  endtask

  function automatic logic [7:0] mask_of(input logic [1:0] ws);
    return 8'hFF >> (2'd3 - ws);
  endfunction

  task automatic send_frame(input logic [7:0] d, input bit badp);
    logic [7:0] md;
    md = d & mask_of(wsel);
    hold(1'b0, OSR);
    send_bits(md, 5 + int'(wsel));
    if (pen) hold((^md) ^ podd ^ badp, OSR);
    hold(1'b1, OSR * (two ? 2 : 1));
    hold(1'b1, 2 * OSR);
  endtask

  task automatic set_cfg(input logic [1:0] ws, input bit pe, input bit po, input bit ts);
    wsel = ws; pen = pe; podd = po; two = ts;
    @(posedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int base;
    logic [7:0] exp_d;
    bit exp_p;
    // R1: reset state
    repeat (5) @(posedge clk);
    #1;
    chk(char_valid == 1'b0, "R1 valid in reset", int'(char_valid), 0);
    chk({perr, ferr, brk} == 3'b000, "R1 tags in reset", int'({perr, ferr, brk}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    base = cap_n;
    hold(1'b1, 30 * OSR);
    chk(cap_n == base, "R1 idle line gives no char", cap_n - base, 0);

    // R3, R4, R5: table of formats
    for (int v = 0; v < NVEC; v++) begin
      set_cfg(VEC[v][13:12], VEC[v][11], VEC[v][10], VEC[v][9]);
      base = cap_n;
      send_frame(VEC[v][8:1], VEC[v][0]);
      exp_d = VEC[v][8:1] & mask_of(VEC[v][13:12]);
      exp_p = VEC[v][11] & VEC[v][0];
      chk(cap_n - base == 1, "R5 one char per frame", cap_n - base, 1);
      chk(cap_d[base] == exp_d, "R3 data", int'(cap_d[base]), int'(exp_d));
      chk(cap_f[base] == {2'b00, exp_p}, "R4 tags", int'(cap_f[base]), int'({2'b00, exp_p}));
    end

    // R2: glitch shorter than half a bit is rejected
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    base = cap_n;
    hold(1'b0, 5);
    hold(1'b1, 3 * OSR);
    chk(cap_n == base, "R2 glitch rejected", cap_n - base, 0);
    send_frame(8'h6E, 1'b0);
    chk(cap_n - base == 1 && cap_d[base] == 8'h6E, "R2 char after glitch", int'(cap_d[base]), 'h6E);

    // R6: low stop bit taken as next start bit
    base = cap_n;
    hold(1'b0, OSR);
    send_bits(8'h5A, 8);
    hold(1'b0, OSR);
    send_bits(8'hC3, 8);
    hold(1'b1, 3 * OSR);
    chk(cap_n - base == 2, "R6 two chars", cap_n - base, 2);
    chk(cap_d[base] == 8'h5A && cap_f[base] == 3'b010, "R6 first char ferr",
        int'({cap_f[base], cap_d[base]}), 'h25A);
    chk(cap_d[base+1] == 8'hC3 && cap_f[base+1] == 3'b000, "R6 resynced char",
        int'({cap_f[base+1], cap_d[base+1]}), 'h0C3);

    // R5: second stop bit low
    set_cfg(2'd3, 1'b0, 1'b0, 1'b1);
    base = cap_n;
    hold(1'b0, OSR);
    send_bits(8'h96, 8);
    hold(1'b1, OSR);
    hold(1'b0, OSR);
    send_bits(8'h69, 8);
    hold(1'b1, 4 * OSR);
    chk(cap_n - base == 2, "R5 two-stop count", cap_n - base, 2);
    chk(cap_d[base] == 8'h96 && cap_f[base] == 3'b010, "R5 second stop low ferr",
        int'({cap_f[base], cap_d[base]}), 'h296);
    chk(cap_d[base+1] == 8'h69 && cap_f[base+1] == 3'b000, "R5 following char",
        int'({cap_f[base+1], cap_d[base+1]}), 'h069);

    // R7: break with even parity enabled
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    base = cap_n;
    hold(1'b0, 3 * 11 * OSR);
    hold(1'b1, 3 * OSR);
    chk(cap_n - base == 1, "R7 one break char", cap_n - base, 1);
    chk(cap_d[base] == 8'h00 && cap_f[base] == 3'b111, "R7 break tags",
        int'({cap_f[base], cap_d[base]}), 'h700);

    // R7: all-low char ending before the frame limit is not a break
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
    base = cap_n;
    hold(1'b0, OSR);
    send_bits(8'h00, 8);
    hold(1'b0, 12);
    hold(1'b1, 3 * OSR);
    chk(cap_n - base == 1, "R7 short low count", cap_n - base, 1);
    chk(cap_d[base] == 8'h00 && cap_f[base] == 3'b010, "R7 short low is ferr only",
        int'({cap_f[base], cap_d[base]}), 'h200);

    // R8: after a break, a short high gap does not re-arm the receiver
    base = cap_n;
    hold(1'b0, 3 * 10 * OSR);
    hold(1'b1, 6);
    hold(1'b0, 2 * OSR);
    hold(1'b1, 3 * OSR);
    send_frame(8'h33, 1'b0);
    chk(cap_n - base == 2, "R8 count after break", cap_n - base, 2);
    chk(cap_f[base] == 3'b111, "R8 break char", int'(cap_f[base]), 'h7);
    chk(cap_d[base+1] == 8'h33 && cap_f[base+1] == 3'b000, "R8 char after recovery",
        int'({cap_f[base+1], cap_d[base+1]}), 'h033);

    summary();
  end
endmodule